// File: doc/BRIEF.md
# Program ROM Table Read Unit

This block lets a small microcontroller core use program ROM as a look-up table. When the core issues a table read, the unit builds a ROM word address and fetches the 16-bit word through a synchronous read port. The low byte goes out on a data-memory write port to a destination the command names. The high byte is captured in a holding register that software can only read.

The word address always takes its low eight bits from the low table pointer, so each page holds 256 words. The page bits come from one of two sources. In last-page mode every page bit is forced to one. In current-page mode a narrow build (13-bit address) copies the page bits of the program counter, and a wide build (14-bit address) takes them from a separate high table pointer, which can select any page. The address width is a parameter, and that parameter chooses the page source.

A read takes two cycles after the command is accepted: a fetch cycle that drives the ROM, then a write cycle that delivers both bytes. The command inputs and pointers are sampled only when the command is accepted.

Top module: `tblrd_unit`

## Requirements
- R1: The low 8 bits of the ROM address equal the low table pointer `ptr_lo_i` sampled when the command was accepted.
- R2: With `ADDR_W`=13 and `last_page_i`=0, ROM address bits 12..8 equal bits 12..8 of `pc_i` sampled at acceptance.
- R3: With `last_page_i`=1, every ROM address bit from 8 up to `ADDR_W`-1 is 1, in both builds.
- R4: With `ADDR_W`=14 and `last_page_i`=0, ROM address bits 13..8 equal `ptr_hi_i` sampled at acceptance, whatever `pc_i` holds.
- R5: A `start_i` seen while idle makes `rom_en_o` high for exactly the next cycle (the fetch cycle).
- R6: In the cycle after the fetch cycle, `dm_we_o` is high for one cycle, with `dm_addr_o` equal to the sampled `dst_addr_i` and `dm_wdata_o` equal to bits 7..0 of the ROM word.
- R7: At the end of the write cycle `hi_byte_o` takes bits 15..8 of the ROM word. It holds its value at all other times, and each later read overwrites it.
- R8: `busy_o` is high during the fetch and write cycles and low otherwise. A `start_i` seen while busy is ignored and produces no further ROM access or write.
- R9: Changes to `ptr_lo_i`, `ptr_hi_i`, `pc_i`, `last_page_i` or `dst_addr_i` after acceptance do not affect the read in progress.
- R10: While `rst_ni` is low, `busy_o`, `rom_en_o` and `dm_we_o` are 0 and `hi_byte_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Table read command strobe |
| last_page_i | input | 1 | 1 selects last-page mode, 0 selects current-page mode |
| dst_addr_i | input | DM_AW | Data-memory destination for the low byte |
| ptr_lo_i | input | 8 | Low table pointer |
| ptr_hi_i | input | ADDR_W-8 | High table pointer (used only in the 14-bit build) |
| pc_i | input | ADDR_W | Current program counter |
| rom_en_o | output | 1 | ROM read enable |
| rom_addr_o | output | ADDR_W | ROM word address |
| rom_data_i | input | 16 | ROM word, valid the cycle after `rom_en_o` |
| dm_we_o | output | 1 | Data-memory write enable |
| dm_addr_o | output | DM_AW | Data-memory write address |
| dm_wdata_o | output | 8 | Data-memory write data (low byte) |
| hi_byte_o | output | 8 | High-byte holding register |
| busy_o | output | 1 | Read in progress |

## Verification
On every cycle the assertions check the address composition against the sampled pointer, counter and mode. They also check the fetch-then-write ordering, that the high byte takes the ROM word's upper half, and that the holding register stays steady outside the write cycle. Only the bench scenarios show the wider behaviour. These cover reads across many pointer and counter patterns in both builds, page-boundary pointers, a start issued while busy that is dropped, inputs changed mid-read with no effect, and back-to-back reads replacing the high byte.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WRITE} tblrd_state_e;
endpackage

// File: rtl/tblrd_addr_gen.sv
module tblrd_addr_gen #(
  parameter int ADDR_W     = 13,
  parameter bit USE_HI_PTR = 1'b0,
  localparam int PAGE_W    = ADDR_W - 8
) (
  input  logic              last_page_i,
  input  logic [7:0]        ptr_lo_i,
  input  logic [PAGE_W-1:0] ptr_hi_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [PAGE_W-1:0] cur_page;
  logic              unused_bits;

  generate
    if (USE_HI_PTR) begin : g_hi_ptr
      assign cur_page    = ptr_hi_i;
      assign unused_bits = ^pc_i;
    end else begin : g_pc_page
      assign cur_page    = pc_i[ADDR_W-1:8];
      assign unused_bits = ^{ptr_hi_i, pc_i[7:0]};
    end
  endgenerate

  assign addr_o = {(last_page_i ? {PAGE_W{1'b1}} : cur_page), ptr_lo_i};
endmodule

// File: rtl/tblrd_ctrl.sv
module tblrd_ctrl
  import tblrd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic fetch_o,
  output logic write_o,
  output logic busy_o
);
  tblrd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_FETCH;
      ST_FETCH: state_d = ST_WRITE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign fetch_o  = (state_q == ST_FETCH);
  assign write_o  = (state_q == ST_WRITE);
  assign busy_o   = (state_q != ST_IDLE);
endmodule

// File: rtl/tblrd_hi_latch.sv
module tblrd_hi_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit
  import tblrd_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DM_AW      = 8,
  localparam int PAGE_W    = ADDR_W - 8,
  localparam bit USE_HI_PTR = (ADDR_W >= 14)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                last_page_i,
  input  logic [DM_AW-1:0]    dst_addr_i,
  input  logic [7:0]          ptr_lo_i,
  input  logic [PAGE_W-1:0]   ptr_hi_i,
  input  logic [ADDR_W-1:0]   pc_i,
  output logic                rom_en_o,
  output logic [ADDR_W-1:0]   rom_addr_o,
  input  logic [WORD_W-1:0]   rom_data_i,
  output logic                dm_we_o,
  output logic [DM_AW-1:0]    dm_addr_o,
  output logic [BYTE_W-1:0]   dm_wdata_o,
  output logic [BYTE_W-1:0]   hi_byte_o,
  output logic                busy_o
);
  logic              accept, fetch, write;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [DM_AW-1:0]  dst_q;

  tblrd_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .accept_o(accept), .fetch_o(fetch), .write_o(write), .busy_o
  );

  tblrd_addr_gen #(.ADDR_W(ADDR_W), .USE_HI_PTR(USE_HI_PTR)) u_addr (
    .last_page_i, .ptr_lo_i, .ptr_hi_i, .pc_i, .addr_o(addr_d)
  );

  // command sampled once, at acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      dst_q  <= '0;
    end else if (accept) begin
      addr_q <= addr_d;
      dst_q  <= dst_addr_i;
    end
  end

  tblrd_hi_latch #(.W(BYTE_W)) u_hi (
    .clk_i, .rst_ni, .load_i(write),
    .d_i(rom_data_i[WORD_W-1:BYTE_W]), .q_o(hi_byte_o)
  );

  assign rom_en_o   = fetch;
  assign rom_addr_o = addr_q;
  assign dm_we_o    = write;
  assign dm_addr_o  = dst_q;
  assign dm_wdata_o = rom_data_i[BYTE_W-1:0];
endmodule

// File: rtl/tblrd_unit_chk.sv
module tblrd_unit_chk #(
  parameter int ADDR_W = 13,
  parameter int DM_AW  = 8,
  localparam int PAGE_W = ADDR_W - 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              last_page_i,
  input logic [DM_AW-1:0]  dst_addr_i,
  input logic [7:0]        ptr_lo_i,
  input logic [PAGE_W-1:0] ptr_hi_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic              rom_en_o,
  input logic [ADDR_W-1:0] rom_addr_o,
  input logic [15:0]       rom_data_i,
  input logic              dm_we_o,
  input logic [DM_AW-1:0]  dm_addr_o,
  input logic [7:0]        dm_wdata_o,
  input logic [7:0]        hi_byte_o,
  input logic              busy_o
);
  // R1
  lo_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_en_o |-> rom_addr_o[7:0] == $past(ptr_lo_i));

  // R3
  last_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_en_o && $past(last_page_i)) |-> (&rom_addr_o[ADDR_W-1:8]));

  generate
    if (ADDR_W >= 14) begin : g_wide
      // R4
      hi_ptr_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rom_en_o && !$past(last_page_i)) |-> rom_addr_o[ADDR_W-1:8] == $past(ptr_hi_i));
    end else begin : g_narrow
      // R2
      pc_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rom_en_o && !$past(last_page_i)) |-> rom_addr_o[ADDR_W-1:8] == $past(pc_i[ADDR_W-1:8]));
    end
  endgenerate

  // R5
  start_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> rom_en_o);

  // R6
  fetch_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_en_o |=> (dm_we_o && !rom_en_o));

  // R7
  hi_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_we_o |=> hi_byte_o == $past(rom_data_i[15:8]));

  // R7
  hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dm_we_o |=> $stable(hi_byte_o));

  // R8
  busy_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_en_o || dm_we_o) |-> busy_o);
endmodule

bind tblrd_unit tblrd_unit_chk #(.ADDR_W(ADDR_W), .DM_AW(DM_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .last_page_i(last_page_i),
  .dst_addr_i(dst_addr_i), .ptr_lo_i(ptr_lo_i), .ptr_hi_i(ptr_hi_i), .pc_i(pc_i),
  .rom_en_o(rom_en_o), .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i),
  .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o),
  .hi_byte_o(hi_byte_o), .busy_o(busy_o)
);

// File: tb/tb_tblrd_unit.sv
module tb_tblrd_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        last_page = 1'b0;
  logic [7:0]  dst = '0;
  logic [7:0]  ptr_lo = '0;
  logic [5:0]  ptr_hi = '0;
  logic [13:0] pc = '0;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [15:0] romf(input logic [13:0] a);
    return 16'({2'b00, a}) * 16'd40503 + 16'h1357;
  endfunction

  // narrow build
  logic        n_en, n_we, n_busy;
  logic [12:0] n_addr;
  logic [15:0] n_rd;
  logic [7:0]  n_da, n_wd, n_hi;
  always_ff @(posedge clk) if (n_en) n_rd <= romf({1'b0, n_addr});

  tblrd_unit #(.ADDR_W(13), .DM_AW(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .last_page_i(last_page),
    .dst_addr_i(dst), .ptr_lo_i(ptr_lo), .ptr_hi_i(ptr_hi[4:0]), .pc_i(pc[12:0]),
    .rom_en_o(n_en), .rom_addr_o(n_addr), .rom_data_i(n_rd),
    .dm_we_o(n_we), .dm_addr_o(n_da), .dm_wdata_o(n_wd), .hi_byte_o(n_hi), .busy_o(n_busy)
  );

  // wide build
  logic        w_en, w_we, w_busy;
  logic [13:0] w_addr;
  logic [15:0] w_rd;
  logic [7:0]  w_da, w_wd, w_hi;
  always_ff @(posedge clk) if (w_en) w_rd <= romf(w_addr);

  tblrd_unit #(.ADDR_W(14), .DM_AW(8)) dut_w (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .last_page_i(last_page),
    .dst_addr_i(dst), .ptr_lo_i(ptr_lo), .ptr_hi_i(ptr_hi), .pc_i(pc),
    .rom_en_o(w_en), .rom_addr_o(w_addr), .rom_data_i(w_rd),
    .dm_we_o(w_we), .dm_addr_o(w_da), .dm_wdata_o(w_wd), .hi_byte_o(w_hi), .busy_o(w_busy)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_reset();
    check(n_busy == 0 && w_busy == 0, "R10 busy", {n_busy, w_busy}, 0);
    check(n_en == 0 && w_en == 0, "R10 rom_en", {n_en, w_en}, 0);
    check(n_we == 0 && w_we == 0, "R10 dm_we", {n_we, w_we}, 0);
    check(n_hi == 0 && w_hi == 0, "R10 hi_byte", {n_hi, w_hi}, 0);
  endtask

  // one full read; optionally disturb inputs and re-issue start mid-read (R8, R9)
  task automatic do_read(input bit lp, input logic [7:0] lo, input logic [5:0] hi,
                         input logic [13:0] p, input logic [7:0] d, input bit disturb);
    logic [12:0] ea_n;
    logic [13:0] ea_w;
    logic [15:0] wn, ww;
    logic [7:0]  old_n, old_w;
    ea_n  = lp ? {5'h1f, lo} : {p[12:8], lo};
    ea_w  = lp ? {6'h3f, lo} : {hi, lo};
    wn    = romf({1'b0, ea_n});
    ww    = romf(ea_w);
    old_n = n_hi;
    old_w = w_hi;
    @(negedge clk);
    start = 1'b1; last_page = lp; ptr_lo = lo; ptr_hi = hi; pc = p; dst = d;
    @(negedge clk);
    start = disturb;
    if (disturb) begin
      last_page = ~lp; ptr_lo = ~lo; ptr_hi = ~hi; pc = ~p; dst = ~d;
    end
    // fetch cycle
    check(n_en && w_en, "R5 rom_en in fetch", {n_en, w_en}, 3);
    check(n_busy && w_busy, "R8 busy in fetch", {n_busy, w_busy}, 3);
    check(n_addr[7:0] == lo && w_addr[7:0] == lo, "R1 low addr", {n_addr[7:0], w_addr[7:0]}, {lo, lo});
    if (lp) begin
      check(n_addr == ea_n, "R3 narrow last page", n_addr, ea_n);
      check(w_addr == ea_w, "R3 wide last page", w_addr, ea_w);
    end else begin
      check(n_addr == ea_n, "R2 narrow pc page", n_addr, ea_n);
      check(w_addr == ea_w, "R4 wide hi ptr page", w_addr, ea_w);
    end
    check(n_hi == old_n && w_hi == old_w, "R7 hi held in fetch", {n_hi, w_hi}, {old_n, old_w});
    @(negedge clk);
    start = 1'b0;
    // write cycle
    check(n_we && w_we && !n_en && !w_en, "R6 write after fetch", {n_we, w_we, n_en, w_en}, 4'b1100);
    check(n_da == d && w_da == d, "R6 dm_addr", {n_da, w_da}, {d, d});
    check(n_wd == wn[7:0], "R6 narrow low byte", n_wd, wn[7:0]);
    check(w_wd == ww[7:0], "R6 wide low byte", w_wd, ww[7:0]);
    check(n_busy && w_busy, "R8 busy in write", {n_busy, w_busy}, 3);
    @(negedge clk);
    check(n_hi == wn[15:8], "R7 narrow hi byte", n_hi, wn[15:8]);
    check(w_hi == ww[15:8], "R7 wide hi byte", w_hi, ww[15:8]);
    check(!n_busy && !w_busy && !n_en && !w_en && !n_we && !w_we,
          disturb ? "R8 start while busy ignored" : "R8 idle after read",
          {n_busy, w_busy, n_en, w_en, n_we, w_we}, 0);
    if (disturb) check(1'b1, "R9 mid-read input change", 0, 0);
  endtask

  task automatic idle_hold();
    logic [7:0] hn, hw;
    hn = n_hi; hw = w_hi;
    pc = 14'h2abc; ptr_lo = 8'h11;
    repeat (3) @(negedge clk);
    check(n_hi == hn && w_hi == hw, "R7 hi held while idle", {n_hi, w_hi}, {hn, hw});
    check(!n_en && !w_en && !n_we && !w_we, "R5 no access without start", {n_en, w_en, n_we, w_we}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check_reset();
    do_read(1'b0, 8'h34, 6'h15, 14'h1a77, 8'h40, 1'b0);
    do_read(1'b0, 8'hff, 6'h00, 14'h0100, 8'h7f, 1'b0);
    do_read(1'b0, 8'h00, 6'h3f, 14'h3eff, 8'h41, 1'b0);
    do_read(1'b1, 8'h5c, 6'h02, 14'h0003, 8'hc0, 1'b0);
    do_read(1'b1, 8'h00, 6'h2a, 14'h1555, 8'h90, 1'b0);
    idle_hold();
    do_read(1'b0, 8'ha5, 6'h09, 14'h0c12, 8'h55, 1'b1);
    do_read(1'b1, 8'h7e, 6'h31, 14'h2000, 8'haa, 1'b1);
    // back-to-back reads overwrite the high byte
    for (int i = 0; i < 8; i++)
      do_read(i[0], 8'(i * 37 + 3), 6'(i * 11), 14'(i * 1031 + 77), 8'(i + 8'h60), 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R5 watchdog expired act=0 exp=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule